// File: doc/BRIEF.md
# UART Status and Interrupt Controller

This block keeps the control-side registers of a simple serial port: an 8-bit baud divisor, an 8-bit control register and a status register with three event flags. Software reaches them through a byte-wide register bus with a two-bit offset. The serial shifter, the baud generator and the data holding registers live elsewhere. They report events to this block through single-cycle strobes: a byte received, the transmit holding register emptied or filled, a frame fully sent, and a read of the receive data register together with the received ninth bit.

From the enable bits and the flags the block raises three interrupt requests: receive complete, transmit holding register empty and transmit complete. The transmit-complete flag clears itself when its request is raised. The empty request is guarded by a shadow flag, so it is raised once for each time the holding register becomes empty and does not repeat while the register stays empty. The receive request repeats every cycle for as long as its flag and enable are both set.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the baud divisor, the control register, all status flags and the shadow empty flag are zero, and no interrupt request is raised.
- R2: Offset 0 holds the baud divisor and offset 1 the control register. Both read back the last byte written and drive `baud_q` and `ctrl_q`. Control bits: 7 receive interrupt enable, 6 transmit-complete interrupt enable, 5 empty interrupt enable, 4 receiver enable, 3 transmitter enable, 2 nine-bit mode, 1 received bit 8, 0 transmit bit 8.
- R3: Offset 2 reads the status: bit 7 receive complete, bit 6 transmit complete, bit 5 holding register empty, the other bits zero. Writing it with bit 6 set clears transmit complete. Zero bits and all other bits have no effect.
- R4: Offset 3 reads zero, and writes to it change no register.
- R5: `irq_rx` is high in every cycle where bit 7 of the control register and the receive-complete flag are both set. Raising it does not clear the flag.
- R6: `irq_tx` is high when bit 6 of the control register and the transmit-complete flag are both set. The flag is clear in the next cycle, so the request lasts one cycle per event.
- R7: `irq_udre` is high only when bit 5 of the control register, the empty flag and the shadow empty flag are all set. Raising it clears only the shadow flag.
- R8: `tx_empty_set` sets both the empty flag and the shadow flag. `tx_empty_clr` clears both.
- R9: `rx_data_rd` clears the receive-complete flag.
- R10: On `rx_data_rd`, control bit 1 takes the value of `rx_bit8` if nine-bit mode (control bit 2) is set, and 0 otherwise. This overrides a control write in the same cycle.
- R11: When a flag's set strobe and one of its clear causes arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| rx_done_set | input | 1 | Receiver finished a byte |
| rx_data_rd | input | 1 | Software read the receive data register |
| rx_bit8 | input | 1 | Ninth bit of the received frame |
| tx_empty_set | input | 1 | Transmit holding register became empty |
| tx_empty_clr | input | 1 | Transmit holding register was written |
| tx_done_set | input | 1 | Last frame fully shifted out |
| baud_q | output | 8 | Baud divisor to the baud generator |
| ctrl_q | output | 8 | Control register to the datapaths |
| irq_rx | output | 1 | Receive complete interrupt request |
| irq_tx | output | 1 | Transmit complete interrupt request |
| irq_udre | output | 1 | Holding register empty interrupt request |

## Verification
A stuck or mis-set flag shows up at the status offset as soon as it is read, and on the matching request output in the cycle after the strobe that should have changed it. A lost or stuck shadow flag shows only through `irq_udre`. The cases that expose it are an empty event while the enable is off followed by turning the enable on, which must give one pulse, and a second empty event while the flag is still set. The bench compares every output with its model on every clock, so a wrong state is reported within one cycle of when it becomes visible.

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
  parameter int AW       = 2,
  parameter int BAUD_OFS = 0,
  parameter int CTRL_OFS = 1,
  parameter int STAT_OFS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          rx_done_set,
  input  logic          rx_data_rd,
  input  logic          rx_bit8,
  input  logic          tx_empty_set,
  input  logic          tx_empty_clr,
  input  logic          tx_done_set,
  output logic [7:0]    baud_q,
  output logic [7:0]    ctrl_q,
  output logic          irq_rx,
  output logic          irq_tx,
  output logic          irq_udre
);
  localparam int C_RXIE = 7, C_TXIE = 6, C_EMIE = 5, C_NINE = 2, C_RB8 = 1;
  localparam int S_RXC = 7, S_TXC = 6, S_EMP = 5;

  logic rxc_q, txc_q, emp_q, shad_q;
  logic wr_baud, wr_ctrl, wr_stat;

  assign wr_baud = bus_wr && (bus_addr == AW'(BAUD_OFS));
  assign wr_ctrl = bus_wr && (bus_addr == AW'(CTRL_OFS));
  assign wr_stat = bus_wr && (bus_addr == AW'(STAT_OFS));

  assign irq_rx   = ctrl_q[C_RXIE] & rxc_q;
  assign irq_tx   = ctrl_q[C_TXIE] & txc_q;
  assign irq_udre = ctrl_q[C_EMIE] & emp_q & shad_q;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(BAUD_OFS))      bus_rdata = baud_q;
    else if (bus_addr == AW'(CTRL_OFS)) bus_rdata = ctrl_q;
    else if (bus_addr == AW'(STAT_OFS)) begin
      bus_rdata[S_RXC] = rxc_q;
      bus_rdata[S_TXC] = txc_q;
      bus_rdata[S_EMP] = emp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_q <= '0;
      ctrl_q <= '0;
    end else begin
      if (wr_baud) baud_q <= bus_wdata;
      if (wr_ctrl) ctrl_q <= bus_wdata;
      if (rx_data_rd) ctrl_q[C_RB8] <= ctrl_q[C_NINE] & rx_bit8;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxc_q  <= 1'b0;
      txc_q  <= 1'b0;
      emp_q  <= 1'b0;
      shad_q <= 1'b0;
    end else begin
      if (rx_done_set)     rxc_q <= 1'b1;
      else if (rx_data_rd) rxc_q <= 1'b0;

      if (tx_done_set) txc_q <= 1'b1;
      else if (irq_tx || (wr_stat && bus_wdata[S_TXC])) txc_q <= 1'b0;

      if (tx_empty_set)      emp_q <= 1'b1;
      else if (tx_empty_clr) emp_q <= 1'b0;

      if (tx_empty_set) shad_q <= 1'b1;
      else if (tx_empty_clr || irq_udre) shad_q <= 1'b0;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (baud_q == 8'h00 && ctrl_q == 8'h00 && !rxc_q && !txc_q && !emp_q && !shad_q));

  assert_rx_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rx && !rx_data_rd) |=> rxc_q);

  assert_tx_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_tx && !tx_done_set) |=> !irq_tx);

  assert_udre_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_udre && !tx_empty_set) |=> !irq_udre);

  assert_empty_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty_set |=> (emp_q && shad_q));

  assert_rxrd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data_rd && !rx_done_set) |=> !rxc_q);

  assert_ninth_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_data_rd && !ctrl_q[C_NINE]) |=> !ctrl_q[C_RB8]);
endmodule

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd2;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic rx_done_set = 0, rx_data_rd = 0, rx_bit8 = 0;
  logic tx_empty_set = 0, tx_empty_clr = 0, tx_done_set = 0;
  logic [7:0] bus_rdata, baud_q, ctrl_q;
  logic irq_rx, irq_tx, irq_udre;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string tag = "R1";

  // behavioural model state
  int m_baud = 0, m_ctrl = 0;
  bit m_rxc = 0, m_txc = 0, m_emp = 0, m_shad = 0;

  always #5 clk = ~clk;

  uart_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_done_set(rx_done_set), .rx_data_rd(rx_data_rd), .rx_bit8(rx_bit8),
    .tx_empty_set(tx_empty_set), .tx_empty_clr(tx_empty_clr), .tx_done_set(tx_done_set),
    .baud_q(baud_q), .ctrl_q(ctrl_q),
    .irq_rx(irq_rx), .irq_tx(irq_tx), .irq_udre(irq_udre));

  task automatic check(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int e_rd;
    bit e_irx, e_itx, e_iem;
    if (!rst_n) begin
      m_baud = 0; m_ctrl = 0; m_rxc = 0; m_txc = 0; m_emp = 0; m_shad = 0;
    end else begin
      e_irx = m_ctrl[7] && m_rxc;
      e_itx = m_ctrl[6] && m_txc;
      e_iem = m_ctrl[5] && m_emp && m_shad;
      case (bus_addr)
        2'd0: e_rd = m_baud;
        2'd1: e_rd = m_ctrl;
        2'd2: e_rd = (m_rxc << 7) | (m_txc << 6) | (m_emp << 5);
        default: e_rd = 0;
      endcase
      check("rdata", bus_rdata, e_rd);
      check("baud_q", baud_q, m_baud);
      check("ctrl_q", ctrl_q, m_ctrl);
      check("irq_rx", irq_rx, e_irx);
      check("irq_tx", irq_tx, e_itx);
      check("irq_udre", irq_udre, e_iem);
      // next state (set beats clear)
      begin
        int old_ctrl;
        old_ctrl = m_ctrl;
        if (bus_wr && bus_addr == 0) m_baud = bus_wdata;
        if (bus_wr && bus_addr == 1) m_ctrl = bus_wdata;
        if (rx_data_rd) m_ctrl[1] = old_ctrl[2] && rx_bit8;
      end
      if (rx_done_set) m_rxc = 1; else if (rx_data_rd) m_rxc = 0;
      if (tx_done_set) m_txc = 1;
      else if (e_itx || (bus_wr && bus_addr == 2 && bus_wdata[6])) m_txc = 0;
      if (tx_empty_set) m_emp = 1; else if (tx_empty_clr) m_emp = 0;
      if (tx_empty_set) m_shad = 1; else if (tx_empty_clr || e_iem) m_shad = 0;
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
      bus_wr = 0; rx_done_set = 0; rx_data_rd = 0; rx_bit8 = 0;
      tx_empty_set = 0; tx_empty_clr = 0; tx_done_set = 0;
      bus_addr = 2'd2;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    bus_addr = a; bus_wr = 1; bus_wdata = d;
    tick();
  endtask

  task automatic look(logic [1:0] a);
    bus_addr = a;
    @(negedge clk);
    tick();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tag = "R1";
    look(0); look(1); look(2); look(3);

    tag = "R2";
    wr(0, 8'hA5); wr(1, 8'h18); look(0); look(1);

    tag = "R4";
    wr(3, 8'hFF); look(3); look(0); look(1); look(2);

    tag = "R5";
    wr(1, 8'h80);
    rx_done_set = 1; tick();
    tick(3);
    tag = "R9";
    rx_data_rd = 1; tick(); tick(2);

    tag = "R10";
    wr(1, 8'h04);
    rx_data_rd = 1; rx_bit8 = 1; tick(); look(1);
    rx_data_rd = 1; rx_bit8 = 0; tick(); look(1);
    rx_data_rd = 1; rx_bit8 = 1; tick(); look(1);
    bus_addr = 1; bus_wr = 1; bus_wdata = 8'h00; rx_data_rd = 1; rx_bit8 = 1; tick(); look(1);
    rx_data_rd = 1; rx_bit8 = 1; tick(); look(1);

    tag = "R6";
    wr(1, 8'h40);
    tx_done_set = 1; tick(); tick(3);
    tx_done_set = 1; tick(); tick();

    tag = "R3";
    wr(1, 8'h00);
    tx_done_set = 1; rx_done_set = 1; tx_empty_set = 1; tick();
    wr(2, 8'h00); look(2);
    wr(2, 8'hBF); look(2);
    wr(2, 8'h40); look(2);
    rx_data_rd = 1; tx_empty_clr = 1; tick(); look(2);

    tag = "R7";
    wr(1, 8'h20);
    tx_empty_set = 1; tick(); tick(3);
    tx_empty_set = 1; tick(); tick(2);
    tag = "R8";
    tx_empty_clr = 1; tick(); tick();
    tx_empty_set = 1; tick(); tick(2);
    wr(1, 8'h00);
    tx_empty_clr = 1; tick();
    tx_empty_set = 1; tick(); tick();
    wr(1, 8'h20); tick(3);

    tag = "R11";
    wr(1, 8'hE0);
    rx_done_set = 1; rx_data_rd = 1; tick(); look(2);
    tx_done_set = 1; bus_addr = 2; bus_wr = 1; bus_wdata = 8'h40; tick(); tick(2);
    tx_empty_set = 1; tx_empty_clr = 1; tick(); tick(2);
    rx_data_rd = 1; tick(); look(2);

    tick(2);
    finish_run();
  end
endmodule